// File: doc/BRIEF.md
# Receive VLAN tag filter and stripper

This block sits in a receive byte stream. It reads the Ethernet header of every frame and looks for an outer VLAN tag and, when stacked tags are enabled, an inner tag. It picks one of the two tags and checks that tag against a programmed value. The check can require a particular tag type, can cover the whole 16-bit control word or only its 12-bit VLAN identifier, and can be inverted. For each frame the block gives one result pulse. The pulse carries a pass or fail flag, a tagged flag, and both captured control words. A 2-bit policy sets whether the outer tag is removed from the stream that is forwarded.

Input bytes go through a fixed delay of eight cycles. This gives the filter decision time to settle before the tag bytes reach the output. Removed bytes appear as cycles with output valid low, and the remaining bytes keep their order. The upstream source must deliver each frame as a contiguous burst of at least 20 bytes, one byte per cycle, and mark the final byte. Frames may follow each other with no idle cycle between them. Configuration inputs are sampled when header byte 19 arrives.

Top module: `vlan_rx_tag_filter`

## Requirements
- R1: Bytes 12-13 of a frame, high byte first, form the outer type field and bytes 14-15 the outer control word. The frame is tagged when this type is 0x8100, or when it is 0x88A8 and cfg_svlan_en_i is 1.
- R2: An inner tag exists only when the frame is tagged, cfg_double_en_i is 1, and bytes 16-17 hold a type that qualifies under R1. Its control word is bytes 18-19.
- R3: One cycle after byte 19 is sampled, res_valid_o pulses for exactly one cycle. At the same time outer_tag_o and inner_tag_o take the control words found, or zero for a tag that is absent, and res_tagged_o shows the R1 result. These outputs hold their value until the next pulse.
- R4: With cfg_use_inner_i set, the filter uses the inner tag when one exists and the outer tag otherwise. With cfg_use_inner_i clear, it always uses the outer tag.
- R5: The type of the selected tag must equal 0x88A8 when cfg_match_svlan_i is 1, or 0x8100 when it is 0. When the inner tag is selected and cfg_inner_any_type_i is 1, any type is accepted.
- R6: With cfg_vid_only_i set, only bits 11:0 of the selected control word are compared with cfg_tag_i. Otherwise all 16 bits are compared.
- R7: For a tagged frame, pass = type accepted AND (compare equal XOR cfg_invert_i). A frame whose type is not accepted always fails.
- R8: An untagged frame always passes, is never stripped, and reports both tag words as zero.
- R9: The value of cfg_strip_i controls stripping of tagged frames: 0 never strips, 1 strips on pass, 2 strips on fail, 3 always strips.
- R10: A stripped frame is forwarded without bytes 12-15, and every other byte keeps its order. An unstripped frame is forwarded unchanged. In both cases out_last_o marks the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_last_i | input | 1 | Final byte of the frame |
| cfg_tag_i | input | 16 | Programmed tag control value |
| cfg_vid_only_i | input | 1 | Compare only the 12-bit identifier |
| cfg_invert_i | input | 1 | Invert the compare result |
| cfg_use_inner_i | input | 1 | Filter on the inner tag when present |
| cfg_match_svlan_i | input | 1 | Required type is 0x88A8 (1) or 0x8100 (0) |
| cfg_svlan_en_i | input | 1 | Treat 0x88A8 as a VLAN type |
| cfg_inner_any_type_i | input | 1 | Skip the type check on the inner tag |
| cfg_double_en_i | input | 1 | Enable inner tag detection |
| cfg_strip_i | input | 2 | Strip policy |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Final output byte of the frame |
| res_valid_o | output | 1 | Per-frame result pulse |
| res_pass_o | output | 1 | Filter passed |
| res_tagged_o | output | 1 | Frame carried an outer tag |
| outer_tag_o | output | 16 | Outer control word or zero |
| inner_tag_o | output | 16 | Inner control word or zero |

## Verification
The assertions check the following on every cycle:
- the result is a one-cycle pulse;
- an untagged frame passes with zeroed tags;
- an inner tag is never reported without an outer one;
- the byte index returns to zero after each final byte;
- policy 0 never schedules a strip.

The choice between inner and outer tag, the type rule, the 12-bit and 16-bit compare, inversion, and the four strip policies all depend on the frame contents together with the configuration. Only the bench scenarios can show these. The bench sweeps every combination of the eight main configuration bits over five tag layouts and three control-word pairings. It checks each result and each forwarded byte sequence.

// File: rtl/vlan_filt_pkg.sv
package vlan_filt_pkg;
  localparam logic [15:0] TPID_CVLAN = 16'h8100;
  localparam logic [15:0] TPID_SVLAN = 16'h88A8;
  localparam int          TAG_BYTES  = 4;

  typedef enum logic [1:0] {
    STRIP_NEVER   = 2'd0,
    STRIP_ON_PASS = 2'd1,
    STRIP_ON_FAIL = 2'd2,
    STRIP_ALWAYS  = 2'd3
  } strip_pol_e;

  function automatic logic is_vlan_type(input logic [15:0] t, input logic s_en);
    return (t == TPID_CVLAN) || (s_en && (t == TPID_SVLAN));
  endfunction
endpackage

// File: rtl/vlan_hdr_capture.sv
module vlan_hdr_capture #(
  parameter int TAG_OFF = 12,
  parameter int IDX_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  input  logic             last_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o,
  output logic [15:0]      t1_o,
  output logic [15:0]      c1_o,
  output logic [15:0]      t2_o,
  output logic [15:0]      c2_o
);
  localparam int HDR_BYTES = 2 * vlan_filt_pkg::TAG_BYTES;
  localparam int LAST_IDX  = TAG_OFF + HDR_BYTES - 1;

  logic [IDX_W-1:0] idx_q;
  logic [7:0]       hdr_q [HDR_BYTES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (valid_i) begin
      if (last_i)             idx_q <= '0;
      else if (idx_q != '1)   idx_q <= idx_q + 1'b1;
    end
  end

  for (genvar k = 0; k < HDR_BYTES - 1; k++) begin : g_hdr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        hdr_q[k] <= '0;
      else if (valid_i && idx_q == IDX_W'(TAG_OFF + k))
        hdr_q[k] <= data_i;
    end
  end

  assign idx_o  = idx_q;
  assign done_o = valid_i && (idx_q == IDX_W'(LAST_IDX));
  assign t1_o   = {hdr_q[0], hdr_q[1]};
  assign c1_o   = {hdr_q[2], hdr_q[3]};
  assign t2_o   = {hdr_q[4], hdr_q[5]};
  assign c2_o   = {hdr_q[6], data_i};

  // R10
  idx_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i) |=> (idx_q == '0));
endmodule

// File: rtl/vlan_tag_match.sv
module vlan_tag_match
  import vlan_filt_pkg::*;
(
  input  logic [15:0] t1_i,
  input  logic [15:0] c1_i,
  input  logic [15:0] t2_i,
  input  logic [15:0] c2_i,
  input  logic [15:0] cfg_tag_i,
  input  logic        cfg_vid_only_i,
  input  logic        cfg_invert_i,
  input  logic        cfg_use_inner_i,
  input  logic        cfg_match_svlan_i,
  input  logic        cfg_svlan_en_i,
  input  logic        cfg_inner_any_type_i,
  input  logic        cfg_double_en_i,
  input  logic [1:0]  cfg_strip_i,
  output logic        tagged_o,
  output logic        pass_o,
  output logic        strip_o,
  output logic [15:0] outer_o,
  output logic [15:0] inner_o
);
  logic        inner_hit, use_inner, type_ok, cmp_eq;
  logic [15:0] sel_type, sel_tci, want_type;
  strip_pol_e  pol;

  always_comb begin
    tagged_o  = is_vlan_type(t1_i, cfg_svlan_en_i);
    inner_hit = tagged_o && cfg_double_en_i && is_vlan_type(t2_i, cfg_svlan_en_i);
    outer_o   = tagged_o  ? c1_i : 16'h0;
    inner_o   = inner_hit ? c2_i : 16'h0;

    use_inner = cfg_use_inner_i && inner_hit;
    sel_type  = use_inner ? t2_i : t1_i;
    sel_tci   = use_inner ? c2_i : c1_i;
    want_type = cfg_match_svlan_i ? TPID_SVLAN : TPID_CVLAN;
    type_ok   = (sel_type == want_type) || (use_inner && cfg_inner_any_type_i);
    cmp_eq    = cfg_vid_only_i ? (sel_tci[11:0] == cfg_tag_i[11:0])
                               : (sel_tci == cfg_tag_i);

    pass_o = tagged_o ? (type_ok && (cmp_eq ^ cfg_invert_i)) : 1'b1;

    pol = strip_pol_e'(cfg_strip_i);
    unique case (pol)
      STRIP_NEVER:   strip_o = 1'b0;
      STRIP_ON_PASS: strip_o = tagged_o && pass_o;
      STRIP_ON_FAIL: strip_o = tagged_o && !pass_o;
      default:       strip_o = tagged_o;
    endcase
  end
endmodule

// File: rtl/vlan_byte_delay.sv
module vlan_byte_delay #(
  parameter int DEPTH = 8,
  parameter int W     = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  logic [W-1:0] st_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     st_q[g] <= '0;
      else if (g == 0) st_q[g] <= in_i;
      else             st_q[g] <= st_q[(g == 0) ? 0 : g - 1];
    end
  end

  assign out_o = st_q[DEPTH-1];
endmodule

// File: rtl/vlan_rx_tag_filter.sv
module vlan_rx_tag_filter
  import vlan_filt_pkg::*;
#(
  parameter int TAG_OFF = 12,
  parameter int IDX_W   = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic [7:0]  in_data_i,
  input  logic        in_last_i,
  input  logic [15:0] cfg_tag_i,
  input  logic        cfg_vid_only_i,
  input  logic        cfg_invert_i,
  input  logic        cfg_use_inner_i,
  input  logic        cfg_match_svlan_i,
  input  logic        cfg_svlan_en_i,
  input  logic        cfg_inner_any_type_i,
  input  logic        cfg_double_en_i,
  input  logic [1:0]  cfg_strip_i,
  output logic        out_valid_o,
  output logic [7:0]  out_data_o,
  output logic        out_last_o,
  output logic        res_valid_o,
  output logic        res_pass_o,
  output logic        res_tagged_o,
  output logic [15:0] outer_tag_o,
  output logic [15:0] inner_tag_o
);
  localparam int HDR_END = TAG_OFF + 2 * TAG_BYTES;
  localparam int DLY     = HDR_END - TAG_OFF;
  localparam int PW      = 2 + IDX_W + 8;

  logic [IDX_W-1:0] idx;
  logic             done;
  logic [15:0]      t1, c1, t2, c2, m_outer, m_inner;
  logic             m_tagged, m_pass, m_strip;

  vlan_hdr_capture #(.TAG_OFF(TAG_OFF), .IDX_W(IDX_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(in_valid_i), .data_i(in_data_i), .last_i(in_last_i),
    .idx_o(idx), .done_o(done),
    .t1_o(t1), .c1_o(c1), .t2_o(t2), .c2_o(c2)
  );

  vlan_tag_match u_match (
    .t1_i(t1), .c1_i(c1), .t2_i(t2), .c2_i(c2),
    .cfg_tag_i(cfg_tag_i), .cfg_vid_only_i(cfg_vid_only_i),
    .cfg_invert_i(cfg_invert_i), .cfg_use_inner_i(cfg_use_inner_i),
    .cfg_match_svlan_i(cfg_match_svlan_i), .cfg_svlan_en_i(cfg_svlan_en_i),
    .cfg_inner_any_type_i(cfg_inner_any_type_i), .cfg_double_en_i(cfg_double_en_i),
    .cfg_strip_i(cfg_strip_i),
    .tagged_o(m_tagged), .pass_o(m_pass), .strip_o(m_strip),
    .outer_o(m_outer), .inner_o(m_inner)
  );

  logic strip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_pass_o   <= 1'b0;
      res_tagged_o <= 1'b0;
      outer_tag_o  <= '0;
      inner_tag_o  <= '0;
      strip_q      <= 1'b0;
    end else begin
      res_valid_o <= done;
      if (done) begin
        res_pass_o   <= m_pass;
        res_tagged_o <= m_tagged;
        outer_tag_o  <= m_outer;
        inner_tag_o  <= m_inner;
        strip_q      <= m_strip;
      end
    end
  end

  // byte 12 leaves the delay line in the cycle strip_q for its frame appears
  logic [PW-1:0]    head;
  logic             h_valid, h_last, h_drop;
  logic [IDX_W-1:0] h_idx;
  logic [7:0]       h_data;

  vlan_byte_delay #(.DEPTH(DLY), .W(PW)) u_dly (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_i({in_valid_i, in_last_i, idx, in_data_i}),
    .out_o(head)
  );

  assign {h_valid, h_last, h_idx, h_data} = head;
  assign h_drop      = strip_q && (h_idx >= IDX_W'(TAG_OFF)) &&
                       (h_idx < IDX_W'(TAG_OFF + TAG_BYTES));
  assign out_valid_o = h_valid && !h_drop;
  assign out_data_o  = h_data;
  assign out_last_o  = h_valid && h_last;

  // R3
  res_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  // R8
  untagged_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_tagged_o) |-> (res_pass_o && outer_tag_o == '0 &&
                                       inner_tag_o == '0 && !strip_q));
  // R2
  inner_needs_outer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && inner_tag_o != '0) |-> res_tagged_o);
  // R9
  never_strip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && $past(cfg_strip_i) == 2'd0) |-> !strip_q);
endmodule

// File: tb/vlan_rx_tag_filter_bench.sv
module vlan_rx_tag_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] VID = 16'h3123;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0;
  logic [7:0] in_data = 0;
  logic [15:0] cfg_tag = VID;
  logic cfg_vid_only = 0, cfg_invert = 0, cfg_use_inner = 0, cfg_match_svlan = 0;
  logic cfg_svlan_en = 0, cfg_inner_any_type = 0, cfg_double_en = 0;
  logic [1:0] cfg_strip = 0;
  logic out_valid, out_last, res_valid, res_pass, res_tagged;
  logic [7:0] out_data;
  logic [15:0] outer_tag, inner_tag;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlan_rx_tag_filter u_vlan_rx_tag_filter (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last),
    .cfg_tag_i(cfg_tag), .cfg_vid_only_i(cfg_vid_only), .cfg_invert_i(cfg_invert),
    .cfg_use_inner_i(cfg_use_inner), .cfg_match_svlan_i(cfg_match_svlan),
    .cfg_svlan_en_i(cfg_svlan_en), .cfg_inner_any_type_i(cfg_inner_any_type),
    .cfg_double_en_i(cfg_double_en), .cfg_strip_i(cfg_strip),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_last_o(out_last),
    .res_valid_o(res_valid), .res_pass_o(res_pass), .res_tagged_o(res_tagged),
    .outer_tag_o(outer_tag), .inner_tag_o(inner_tag)
  );

  logic [7:0]  exp_bytes[$];
  int          exp_len[$];
  logic        exp_pass[$], exp_tagged[$];
  logic [15:0] exp_outer[$], exp_inner[$];

  function automatic logic vt(input logic [15:0] t, input logic sen);
    return t == 16'h8100 || (sen && t == 16'h88A8);
  endfunction

  task automatic note(input bit ok, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, expv);
    end
  endtask

  // monitor
  int  got_cnt = 0;
  bit  mism = 0;
  always @(negedge clk) if (rst_n) begin
    if (res_valid) begin
      if (exp_pass.size() == 0) note(0, "R3 unexpected result", 1, 0);
      else begin
        logic p, t; logic [15:0] o, i;
        p = exp_pass.pop_front(); t = exp_tagged.pop_front();
        o = exp_outer.pop_front(); i = exp_inner.pop_front();
        note(res_pass == p, "R4/R5/R6/R7/R8 pass flag", int'(res_pass), int'(p));
        note(res_tagged == t && outer_tag == o && inner_tag == i,
             "R1/R2/R3 tags {tagged,outer,inner}",
             int'({res_tagged, outer_tag, inner_tag}), int'({t, o, i}));
      end
    end
    if (out_valid) begin
      if (exp_bytes.size() == 0) mism = 1;
      else if (exp_bytes.pop_front() != out_data) mism = 1;
      got_cnt++;
      if (out_last) begin
        int el;
        el = (exp_len.size() != 0) ? exp_len.pop_front() : -1;
        note(!mism && got_cnt == el, "R9/R10 stream {mismatch,len}",
             int'(mism) * 256 + got_cnt, el);
        got_cnt = 0; mism = 0;
      end
    end
  end

  task automatic send(input int kind, input int var_i, input int seed, input logic tcd);
    logic [15:0] t1, c1, t2, c2;
    logic [7:0]  fb[24];
    int          len;
    logic tg, ih, ui, tok, cm, ps, sp;
    logic [15:0] st, sc;
    len = 20 + (seed % 4);
    case (kind)
      0: begin t1 = 16'h0800; t2 = 16'h8100; end
      1: begin t1 = 16'h8100; t2 = 16'h0800; end
      2: begin t1 = 16'h88A8; t2 = 16'h0800; end
      3: begin t1 = 16'h8100; t2 = 16'h8100; end
      default: begin t1 = 16'h88A8; t2 = 16'h8100; end
    endcase
    case (var_i)
      0: begin c1 = VID;      c2 = 16'hA123; end
      1: begin c1 = 16'hA123; c2 = VID;      end
      default: begin c1 = 16'h0456; c2 = 16'h0789; end
    endcase
    for (int i = 0; i < 24; i++) fb[i] = 8'((i * 7 + seed) & 8'hFF);
    fb[12] = t1[15:8]; fb[13] = t1[7:0]; fb[14] = c1[15:8]; fb[15] = c1[7:0];
    fb[16] = t2[15:8]; fb[17] = t2[7:0]; fb[18] = c2[15:8]; fb[19] = c2[7:0];
    // expected model from the requirements
    tg = vt(t1, cfg_svlan_en);
    ih = tg && cfg_double_en && vt(t2, cfg_svlan_en);
    ui = cfg_use_inner && ih;
    st = ui ? t2 : t1;
    sc = ui ? c2 : c1;
    tok = (st == (cfg_match_svlan ? 16'h88A8 : 16'h8100)) || (ui && tcd);
    cm  = cfg_vid_only ? (sc[11:0] == VID[11:0]) : (sc == VID);
    ps  = tg ? (tok && (cm != cfg_invert)) : 1'b1;
    sp  = tg && (cfg_strip == 2'd3 || (cfg_strip == 2'd1 && ps) || (cfg_strip == 2'd2 && !ps));
    exp_pass.push_back(ps); exp_tagged.push_back(tg);
    exp_outer.push_back(tg ? c1 : 16'h0); exp_inner.push_back(ih ? c2 : 16'h0);
    for (int i = 0; i < len; i++)
      if (!(sp && i >= 12 && i < 16)) exp_bytes.push_back(fb[i]);
    exp_len.push_back(sp ? len - 4 : len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = fb[i]; in_last = (i == len - 1);
    end
  endtask

  initial begin
    int seed = 0;
    repeat (3) @(negedge clk);
    note(!out_valid && !res_valid && outer_tag == 0 && inner_tag == 0,
         "R3 reset state", int'({out_valid, res_valid}), 0);
    rst_n = 1;
    for (int c = 0; c < 256; c++) begin
      for (int k = 0; k < 5; k++) begin
        for (int v = 0; v < 3; v++) begin
          @(negedge clk);
          in_valid = 0; in_last = 0;
          cfg_strip = c[1:0]; cfg_invert = c[2]; cfg_vid_only = c[3];
          cfg_use_inner = c[4]; cfg_match_svlan = c[5]; cfg_svlan_en = c[6];
          cfg_double_en = c[7]; cfg_inner_any_type = c[1] ^ c[2] ^ c[6] ^ v[0];
          send(k, v, seed, cfg_inner_any_type);
          seed++;
        end
      end
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
    repeat (20) @(negedge clk);
    note(exp_bytes.size() == 0 && exp_len.size() == 0 && exp_pass.size() == 0,
         "R3/R10 all frames delivered", exp_bytes.size() + exp_pass.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    note(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule